// File: doc/BRIEF.md
# Shared and Banked Interrupt Acknowledge Arbiter

This block is a reduced interrupt distributor with a CPU-side slice for up to four processors. It takes interrupt lines, holds their pending state (a level line is pending while high, an edge line latches its rising edge), routes them to the processors and drives one request wire per processor. Each processor reaches the block through a small register port. The port supports three accesses: an acknowledge read, which claims the lowest eligible interrupt and returns its ID; an end-of-interrupt write; and a deactivate write, which releases the interrupt.

The ID space has two kinds of interrupt. IDs from 0 up to the banked count are per-processor. Every processor has its own lines, its own pending state and its own active state for them, so each processor takes its own copy. IDs above that range are shared. Exclusion for a shared ID rests on its active bit, not on its pending bit. A level line that stays high keeps the interrupt pending, so the pending bit cannot exclude other processors. Once one processor has acknowledged a shared ID, every other processor is refused it until the ID is deactivated.

Top module: `irq_share_arb`

## Requirements
- R1: After reset no interrupt is active or pending, every shared target mask is zero, every line is in level mode, all `cpu_irq` bits are low, and an acknowledge read returns 1023.
- R2: A shared ID (32..63) held active by one processor is never returned to another: their acknowledge reads return 1023 until it is deactivated. When several processors acknowledge the same shared ID in one cycle, the lowest-numbered one receives it and the rest receive 1023.
- R3: A read at address 0x00C claims the lowest-numbered eligible ID for that processor. The ID appears on its `cpu_rdata` slice from the clock edge that takes the read. With nothing eligible, the value is 1023.
- R4: A shared ID is routed to processor c only when bit c of its 8-bit target mask is set. Mask bits at or above the processor count are ignored.
- R5: Banked IDs (0..31) use per-processor lines (`bnk_in` bit c*32+id). Each processor can acknowledge and deactivate its own copy independently of the others.
- R6: `cpu_irq[c]` is high exactly when some ID routed to c is pending and not active. For a shared ID that means active nowhere; for a banked ID it means not active on c.
- R7: A write of an ID to address 0x010 (end of interrupt) leaves the active state unchanged. A write of an ID to address 0x1000 clears its active bit. A level line still high then raises the request again.
- R8: In edge mode an interrupt becomes pending on a rising line edge and stays pending after the line falls, until it is acknowledged. In level mode it is pending exactly while the line is high.
- R9: A configuration write (`cfg_we`) sets the mode of `cfg_id` (`cfg_edge` 1 = edge) and, for shared IDs, its target mask. The new values take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shr_in | input | NIRQ-NBANK | Shared interrupt lines; bit j is ID NBANK+j |
| bnk_in | input | NCPU*NBANK | Banked lines; bit c*NBANK+i is ID i of processor c |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_id | input | 10 | ID being configured |
| cfg_edge | input | 1 | 1 = edge mode, 0 = level mode |
| cfg_tgt | input | 8 | Target mask for a shared ID |
| cpu_rd | input | NCPU | Per-processor read strobe |
| cpu_wr | input | NCPU | Per-processor write strobe |
| cpu_addr | input | NCPU*13 | Per-processor address |
| cpu_wdata | input | NCPU*10 | Per-processor write data (an ID) |
| cpu_rdata | output | NCPU*10 | Per-processor acknowledged ID, registered |
| cpu_irq | output | NCPU | Per-processor interrupt request |

## Verification
On every cycle, the checker confirms four things. Every acknowledged ID is in range or spurious. A shared ID handed out was inactive before the acknowledge and is active afterwards. Two processors never receive the same shared ID in one cycle. Reset leaves nothing active.

Only the bench scenarios can show the rest: the routing of each mask value to the requests, the lowest-ID choice, banked copies taken side by side, end of interrupt leaving ownership in place, a held level line re-raising the request after deactivate, and an edge being latched and then consumed.

// File: rtl/irq_share_arb_pkg.sv
// Package: shared constants and the access-kind type for the arbiter.
// Assumes a 13-bit processor-port address and 10-bit interrupt IDs.
package irq_share_arb_pkg;
    localparam int ID_W   = 10;
    localparam int ADDR_W = 13;
    localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'd1023;
    localparam logic [ADDR_W-1:0] OFS_ACK     = 13'h00C;
    localparam logic [ADDR_W-1:0] OFS_EOI     = 13'h010;
    localparam logic [ADDR_W-1:0] OFS_DEACT   = 13'h1000;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_ACK,
        ACC_EOI,
        ACC_DEACT
    } acc_kind_e;
endpackage

// File: rtl/irq_pend_bank.sv
// Pending state for a vector of interrupt lines.
// Level mode: pending follows the line. Edge mode: a rising edge sets a latch,
// which is cleared by clr (acknowledge). A new edge wins over a same-cycle clear.
module irq_pend_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line,
    input  logic [N-1:0] edge_mode,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] prev_q;
    logic [N-1:0] lat_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Track the previous line value and the edge latch for one line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[i] <= 1'b0;
                lat_q[i]  <= 1'b0;
            end else begin
                prev_q[i] <= line[i];
                if (!edge_mode[i])
                    lat_q[i] <= 1'b0;
                else if (line[i] && !prev_q[i])
                    lat_q[i] <= 1'b1;
                else if (clr[i])
                    lat_q[i] <= 1'b0;
            end
        end
        assign pend[i] = edge_mode[i] ? lat_q[i] : line[i];
    end
endmodule

// File: rtl/irq_lowest.sv
// Finds the lowest set bit of a vector; combinational.
// idx is only meaningful when found is high.
module irq_lowest #(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so that the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_cpu_port.sv
// One processor's register port: decodes acknowledge, end-of-interrupt and
// deactivate accesses, and registers the acknowledged ID for read-back.
// Assumes at most one of rd/wr is asserted per cycle.
module irq_cpu_port
    import irq_share_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ID_W-1:0]   ack_id,
    output acc_kind_e         kind,
    output logic [ID_W-1:0]   rdata
);
    // Classify the access on this cycle.
    always_comb begin
        if (rd && addr == OFS_ACK)
            kind = ACC_ACK;
        else if (wr && addr == OFS_EOI)
            kind = ACC_EOI;
        else if (wr && addr == OFS_DEACT)
            kind = ACC_DEACT;
        else
            kind = ACC_NONE;
    end

    // Hold the ID granted by the last acknowledge read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= SPURIOUS_ID;
        else if (kind == ACC_ACK)
            rdata <= ack_id;
    end
endmodule

// File: rtl/irq_share_arb.sv
// Top of the arbiter: configuration, pending and active state, per-processor
// selection and the one-of-many grant of shared IDs.
// Assumes NCPU <= TGT_W and NBANK < NIRQ. Deactivate may come from any processor.
module irq_share_arb
    import irq_share_arb_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int NIRQ  = 64,
    parameter int NBANK = 32,
    parameter int TGT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NIRQ-NBANK-1:0]    shr_in,
    input  logic [NCPU*NBANK-1:0]    bnk_in,
    input  logic                     cfg_we,
    input  logic [ID_W-1:0]          cfg_id,
    input  logic                     cfg_edge,
    input  logic [TGT_W-1:0]         cfg_tgt,
    input  logic [NCPU-1:0]          cpu_rd,
    input  logic [NCPU-1:0]          cpu_wr,
    input  logic [NCPU*ADDR_W-1:0]   cpu_addr,
    input  logic [NCPU*ID_W-1:0]     cpu_wdata,
    output logic [NCPU*ID_W-1:0]     cpu_rdata,
    output logic [NCPU-1:0]          cpu_irq
);
    localparam int NSHR = NIRQ - NBANK;
    localparam int IXW  = $clog2(NIRQ);

    logic [NIRQ-1:0]  edge_cfg;
    logic [TGT_W-1:0] tgt [NSHR];

    logic [NSHR-1:0]  sh_pend, sh_act, sh_take, sh_deact;
    logic [NBANK-1:0] bk_pend [NCPU];
    logic [NBANK-1:0] bk_act  [NCPU];
    logic [NBANK-1:0] bk_take [NCPU];
    logic [NBANK-1:0] bk_deact[NCPU];

    logic [NIRQ-1:0]  elig [NCPU];
    logic [NSHR-1:0]  sh_route [NCPU];
    logic [NCPU-1:0]  found, take;
    logic [IXW-1:0]   pick [NCPU];
    acc_kind_e        kind [NCPU];
    logic [ID_W-1:0]  ack_id [NCPU];

    // Configuration store: mode per ID, target mask per shared ID.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cfg <= '0;
            for (int j = 0; j < NSHR; j++) tgt[j] <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < NIRQ; i++)
                if (cfg_id == ID_W'(i)) edge_cfg[i] <= cfg_edge;
            for (int j = 0; j < NSHR; j++)
                if (cfg_id == ID_W'(j + NBANK)) tgt[j] <= cfg_tgt;
        end
    end

    irq_pend_bank #(.N(NSHR)) u_sh_pend (
        .clk(clk), .rst_n(rst_n), .line(shr_in),
        .edge_mode(edge_cfg[NIRQ-1:NBANK]), .clr(sh_take), .pend(sh_pend)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        irq_cpu_port u_port (
            .clk(clk), .rst_n(rst_n), .rd(cpu_rd[c]), .wr(cpu_wr[c]),
            .addr(cpu_addr[c*ADDR_W +: ADDR_W]), .ack_id(ack_id[c]),
            .kind(kind[c]), .rdata(cpu_rdata[c*ID_W +: ID_W])
        );

        irq_pend_bank #(.N(NBANK)) u_bk_pend (
            .clk(clk), .rst_n(rst_n), .line(bnk_in[c*NBANK +: NBANK]),
            .edge_mode(edge_cfg[NBANK-1:0]), .clr(bk_take[c]), .pend(bk_pend[c])
        );

        // Column c of the target masks, limited to implemented processors.
        always_comb begin
            for (int j = 0; j < NSHR; j++) sh_route[c][j] = tgt[j][c];
        end

        assign elig[c]    = {sh_pend & ~sh_act & sh_route[c], bk_pend[c] & ~bk_act[c]};
        assign cpu_irq[c] = |elig[c];

        irq_lowest #(.N(NIRQ), .IW(IXW)) u_pick (
            .vec(elig[c]), .found(found[c]), .idx(pick[c])
        );

        // Banked active state for this processor.
        always_ff @(posedge clk) begin
            if (!rst_n) bk_act[c] <= '0;
            else        bk_act[c] <= (bk_act[c] & ~bk_deact[c]) | bk_take[c];
        end
    end

    // Grant resolution: lower processor wins a shared ID picked by several.
    always_comb begin
        sh_take  = '0;
        sh_deact = '0;
        for (int c = 0; c < NCPU; c++) begin
            logic lost;
            logic [ID_W-1:0] did;
            lost = 1'b0;
            for (int c2 = 0; c2 < c; c2++)
                if (kind[c2] == ACC_ACK && found[c2] && pick[c2] == pick[c] &&
                    pick[c] >= IXW'(NBANK))
                    lost = 1'b1;
            take[c]     = (kind[c] == ACC_ACK) && found[c] && !lost;
            ack_id[c]   = take[c] ? ID_W'(pick[c]) : SPURIOUS_ID;
            bk_take[c]  = '0;
            bk_deact[c] = '0;
            did         = cpu_wdata[c*ID_W +: ID_W];
            for (int i = 0; i < NBANK; i++) begin
                if (take[c] && pick[c] == IXW'(i)) bk_take[c][i] = 1'b1;
                if (kind[c] == ACC_DEACT && did == ID_W'(i)) bk_deact[c][i] = 1'b1;
            end
            for (int j = 0; j < NSHR; j++) begin
                if (take[c] && pick[c] == IXW'(j + NBANK)) sh_take[j] = 1'b1;
                if (kind[c] == ACC_DEACT && did == ID_W'(j + NBANK)) sh_deact[j] = 1'b1;
            end
        end
    end

    // Shared active state: the single owner record for one-of-many delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_act <= '0;
        else        sh_act <= (sh_act & ~sh_deact) | sh_take;
    end
endmodule

// File: rtl/irq_share_arb_chk.sv
// Checker for irq_share_arb: ID range, one-of-many exclusion and reset state.
// Observes the ports plus the shared active vector.
module irq_share_arb_chk
    import irq_share_arb_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int NIRQ  = 64,
    parameter int NBANK = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCPU-1:0]        cpu_rd,
    input logic [NCPU*ADDR_W-1:0] cpu_addr,
    input logic [NCPU*ID_W-1:0]   cpu_rdata,
    input logic [NIRQ-NBANK-1:0]  sh_act
);
    localparam int NSHR = NIRQ - NBANK;
    localparam int SW   = $clog2(NSHR);

    logic [NCPU-1:0] ack_q;
    logic [NSHR-1:0] sh_act_q;
    logic [ID_W-1:0] rid [NCPU];
    logic [NCPU-1:0] is_sh, cur_bit, prv_bit;

    // Remember which processors acknowledged, and the prior active vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q    <= '0;
            sh_act_q <= '0;
        end else begin
            for (int c = 0; c < NCPU; c++)
                ack_q[c] <= cpu_rd[c] && cpu_addr[c*ADDR_W +: ADDR_W] == OFS_ACK;
            sh_act_q <= sh_act;
        end
    end

    // Decode each returned ID into its shared index and active bits.
    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            logic [ID_W-1:0] d;
            rid[c]     = cpu_rdata[c*ID_W +: ID_W];
            is_sh[c]   = rid[c] >= ID_W'(NBANK) && rid[c] < ID_W'(NIRQ);
            d          = rid[c] - ID_W'(NBANK);
            cur_bit[c] = sh_act[d[SW-1:0]];
            prv_bit[c] = sh_act_q[d[SW-1:0]];
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> sh_act == '0); // R1

    for (genvar c = 0; c < NCPU; c++) begin : g_c
        AST_ACK_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            ack_q[c] |-> (rid[c] < ID_W'(NIRQ) || rid[c] == SPURIOUS_ID)); // R3
        AST_SHARED_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_q[c] && is_sh[c]) |-> (!prv_bit[c] && cur_bit[c])); // R2
        for (genvar b = c + 1; b < NCPU; b++) begin : g_b
            AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_q[c] && ack_q[b] && is_sh[c]) |-> rid[c] != rid[b]); // R2
        end
    end
endmodule

bind irq_share_arb irq_share_arb_chk #(.NCPU(NCPU), .NIRQ(NIRQ), .NBANK(NBANK)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_rdata(cpu_rdata), .sh_act(sh_act)
);

// File: tb/test_irq_share_arb.sv
`timescale 1ns/1ps
module test_irq_share_arb;
    localparam int NCPU = 4, NIRQ = 64, NBANK = 32, AW = 13, IW = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NIRQ-NBANK-1:0] shr_in = '0;
    logic [NCPU*NBANK-1:0] bnk_in = '0;
    logic cfg_we = 1'b0, cfg_edge = 1'b0;
    logic [IW-1:0] cfg_id = '0;
    logic [7:0] cfg_tgt = '0;
    logic [NCPU-1:0] cpu_rd = '0, cpu_wr = '0;
    logic [NCPU*AW-1:0] cpu_addr = '0;
    logic [NCPU*IW-1:0] cpu_wdata = '0;
    logic [NCPU*IW-1:0] cpu_rdata;
    logic [NCPU-1:0] cpu_irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_share_arb i_irq_share_arb (
        .clk(clk), .rst_n(rst_n), .shr_in(shr_in), .bnk_in(bnk_in),
        .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_edge(cfg_edge), .cfg_tgt(cfg_tgt),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_irq(cpu_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg(input int id, input bit edg, input int tg);
        @(negedge clk);
        cfg_we = 1; cfg_id = IW'(id); cfg_edge = edg; cfg_tgt = 8'(tg);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic ack(input int c, output int id);
        @(negedge clk);
        cpu_rd[c] = 1; cpu_addr[c*AW +: AW] = 13'h00C;
        @(negedge clk);
        cpu_rd[c] = 0;
        id = int'(cpu_rdata[c*IW +: IW]);
    endtask

    task automatic ack2(input int a, input int b, output int ia, output int ib);
        @(negedge clk);
        cpu_rd[a] = 1; cpu_addr[a*AW +: AW] = 13'h00C;
        cpu_rd[b] = 1; cpu_addr[b*AW +: AW] = 13'h00C;
        @(negedge clk);
        cpu_rd[a] = 0; cpu_rd[b] = 0;
        ia = int'(cpu_rdata[a*IW +: IW]);
        ib = int'(cpu_rdata[b*IW +: IW]);
    endtask

    task automatic wr(input int c, input int addr, input int id);
        @(negedge clk);
        cpu_wr[c] = 1; cpu_addr[c*AW +: AW] = AW'(addr); cpu_wdata[c*IW +: IW] = IW'(id);
        @(negedge clk);
        cpu_wr[c] = 0;
    endtask

    initial begin
        int r, s;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 irq after reset", int'(cpu_irq), 0);
        ack(0, r); check("R1 ack with nothing pending", r, 1023);

        // R4/R9: target mask sweep on shared ID 40, upper mask bits must be ignored
        shr_in[40-32] = 1;
        #1 check("R4 mask zero after reset", int'(cpu_irq), 0);
        for (int m = 0; m < 16; m++) begin
            cfg(40, 0, (m % 2 == 1) ? (m | 8'hF0) : m);
            check("R4 routing", int'(cpu_irq), m);
        end
        shr_in[40-32] = 0;
        cfg(40, 0, 0);

        // R2/R6/R7: one-of-many on level ID 33 held high
        cfg(33, 0, 8'hFF);
        shr_in[1] = 1;
        #1 check("R6 all requested", int'(cpu_irq), 15);
        ack(1, r); check("R3 cpu1 gets 33", r, 33);
        check("R6 requests drop while active", int'(cpu_irq), 0);
        ack(0, r); check("R2 cpu0 refused", r, 1023);
        wr(1, 'h010, 33);
        ack(0, r); check("R7 EOI keeps ownership", r, 1023);
        wr(1, 'h1000, 33);
        check("R7 level re-raise after deactivate", int'(cpu_irq), 15);
        ack2(2, 3, r, s);
        check("R2 lower cpu wins tie", r, 33);
        check("R2 higher cpu spurious on tie", s, 1023);
        wr(2, 'h1000, 33);
        shr_in[1] = 0;
        #1 check("R6 idle after line low", int'(cpu_irq), 0);

        // R3: lowest ID chosen first
        cfg(35, 0, 8'hFF); cfg(45, 0, 8'hFF);
        shr_in[3] = 1; shr_in[13] = 1;
        ack(0, r); check("R3 lowest first", r, 35);
        ack(0, r); check("R3 next lowest", r, 45);
        ack(0, r); check("R3 none left", r, 1023);
        wr(0, 'h1000, 35); wr(0, 'h1000, 45);
        shr_in[3] = 0; shr_in[13] = 0;

        // R5: banked ID 20 taken by every processor independently
        for (int c = 0; c < NCPU; c++) bnk_in[c*NBANK + 20] = 1;
        #1 check("R5 banked request all", int'(cpu_irq), 15);
        for (int c = 0; c < NCPU; c++) begin
            ack(c, r); check("R5 banked copy", r, 20);
        end
        check("R6 banked all active", int'(cpu_irq), 0);
        wr(0, 'h1000, 20);
        check("R5 deactivate only own copy", int'(cpu_irq), 1);
        for (int c = 1; c < NCPU; c++) wr(c, 'h1000, 20);
        for (int c = 0; c < NCPU; c++) bnk_in[c*NBANK + 20] = 0;
        #1 check("R5 banked idle", int'(cpu_irq), 0);

        // R8: edge mode on shared ID 50 routed to cpu2
        cfg(50, 1, 8'h04);
        @(negedge clk); shr_in[18] = 1;
        @(negedge clk); shr_in[18] = 0;
        @(negedge clk);
        check("R8 edge latched", int'(cpu_irq), 4);
        ack(2, r); check("R8 edge ack id", r, 50);
        wr(2, 'h1000, 50);
        check("R8 edge consumed", int'(cpu_irq), 0);
        ack(2, r); check("R8 nothing after consume", r, 1023);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule